// File: doc/BRIEF.md
# Oscillator-Timed Pulse-Width Modulator

This block makes a pulse train in which two independent sources set the two halves of the waveform. A phase accumulator sets how long each pulse lasts. A period trigger sets when each pulse begins. The trigger comes from either a free-running internal period timer or an external event pin, such as a zero-current detector in a power stage. A small set/clear output controller joins the two sources. A trigger sets the output. The accumulator's carry-out clears it.

When a pulse starts, the accumulator is cleared to zero and the current increment value is latched. On each clock cycle of the pulse, the latched increment is added to the 20-bit accumulator. When the sum carries out of bit 19, the pulse ends. The pulse width in clock cycles is therefore ceil(2^20 / increment), whichever trigger source is in use. Triggers that arrive during a pulse are dropped. An increment of zero blocks new pulses.

Top module: `hrpwm_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `pwm_o` and `busy_o` are low.
- R2: A selected trigger that arrives while no pulse is active, with a nonzero `inc_val_i`, sets `pwm_o` on the same clock edge that samples the trigger.
- R3: A pulse started with increment value N stays high for exactly ceil(2^20 / N) clock cycles. The accumulator is cleared at the start of the pulse, N is added on every active cycle, and the carry out of bit 19 clears the output.
- R4: With `trig_sel_i` = 0 (internal timer), pulses start every PERIOD_LEN cycles (default 64) when the pulse width is shorter than PERIOD_LEN. Edges on `ext_trig_i` have no effect in this mode.
- R5: With `trig_sel_i` = 1 (external), a rising edge of `ext_trig_i` that is set up before clock edge k makes `pwm_o` high after edge k+2. A level held high starts only one pulse, and the internal timer starts none.
- R6: A trigger that arrives while a pulse is active is ignored, including on the cycle in which the accumulator overflows. In timer mode with a width W >= PERIOD_LEN, successive rises of `pwm_o` are therefore PERIOD_LEN*(floor(W/PERIOD_LEN)+1) cycles apart.
- R7: `inc_val_i` is latched only when a pulse starts. A change during a pulse leaves that pulse's width unchanged and takes effect from the next pulse.
- R8: If `inc_val_i` is zero when a trigger arrives, no pulse starts and `pwm_o` stays low.
- R9: `busy_o` is high exactly on the cycles in which a pulse is active, so it always equals `pwm_o`.
- R10: For the same increment, the pulse width is the same with either trigger source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_val_i | input | 20 | Accumulator increment; 0 blocks new pulses |
| trig_sel_i | input | 1 | Trigger source: 0 = internal period timer, 1 = external pin |
| ext_trig_i | input | 1 | Asynchronous external trigger; its rising edge counts |
| pwm_o | output | 1 | Modulated output |
| busy_o | output | 1 | High while a pulse is active |

## Verification
An internal trigger sets the output on the next clock edge. An external edge needs two synchronizer edges plus the set edge, so its pulse appears after the third clock edge following the pin change. The bench asserts that the output is still low after the first two edges and high after the third. All outputs are sampled on the falling clock edge, after the last register that feeds them has settled. Each width check counts falling-edge samples from the first high sample to the first low sample. Each period check adds that width to the number of low samples before the next rise.

// File: rtl/hrpwm_pkg.sv
// Shared types for the oscillator-timed pulse-width modulator.
// Assumes: only the enum encoding below is visible at the top-level ports.
package hrpwm_pkg;

    // Trigger-source select, as driven on trig_sel_i
    typedef enum logic {
        TRIG_TIMER = 1'b0,
        TRIG_EXT   = 1'b1
    } trig_src_e;

endpackage : hrpwm_pkg

// File: rtl/hrpwm_period_timer.sv
// Free-running period timer. Its tick is high for one cycle in every
// PERIOD_LEN cycles.
// Assumes: PERIOD_LEN >= 2; the first tick comes PERIOD_LEN-1 edges
// after reset is released.
module hrpwm_period_timer #(
    parameter int PERIOD_LEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (PERIOD_LEN > 2) ? $clog2(PERIOD_LEN) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count 0..PERIOD_LEN-1 and wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tick on the last count of each period
    always_comb begin
        tick_o = (cnt_q == LAST);
    end

endmodule : hrpwm_period_timer

// File: rtl/hrpwm_ext_trig.sv
// External trigger conditioner. It synchronizes an asynchronous pin and
// makes a one-cycle pulse for each rising edge.
// Assumes: the pin stays at each level for at least SYNC_STAGES+1 clock
// cycles. A pin change set up before edge k gives an edge pulse in the
// cycle after edge k+SYNC_STAGES-1.
module hrpwm_ext_trig #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    logic [SYNC_STAGES:0] shr_q;

    // Synchronizer chain plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shr_q <= '0;
        end else begin
            shr_q <= {shr_q[SYNC_STAGES-1:0], pin_i};
        end
    end

    // Rising edge: synchronized level high, previous level low
    always_comb begin
        rise_o = shr_q[SYNC_STAGES-1] & ~shr_q[SYNC_STAGES];
    end

endmodule : hrpwm_ext_trig

// File: rtl/hrpwm_nco.sv
// Phase accumulator that times the pulse width. On start it clears the
// accumulator and latches the increment. While run_i is high it adds the
// latched increment every cycle and raises ovf_o in the cycle whose sum
// carries out of the top bit.
// Assumes: start_i and run_i are never high together.
module hrpwm_nco #(
    parameter int ACC_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             run_i,
    input  logic [ACC_W-1:0] inc_i,
    output logic             ovf_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] inc_q;
    logic [ACC_W:0]   sum;

    // Next accumulator value, with the carry in the top bit
    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, inc_q};
        ovf_o = run_i & sum[ACC_W];
    end

    // Clear and latch on start; accumulate while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            inc_q <= '0;
        end else if (start_i) begin
            acc_q <= '0;
            inc_q <= inc_i;
        end else if (run_i) begin
            acc_q <= sum[ACC_W] ? '0 : sum[ACC_W-1:0];
        end
    end

endmodule : hrpwm_nco

// File: rtl/hrpwm_out_ctl.sv
// Set/clear output controller. An idle trigger with a nonzero increment
// sets the output. An accumulator overflow clears it. Triggers that come
// while the output is set are dropped.
// Assumes: ovf_i is only high while the output is set.
module hrpwm_out_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic inc_nz_i,
    input  logic ovf_i,
    output logic start_o,
    output logic active_o
);
    logic act_q;

    // Start only when idle and the increment is usable
    always_comb begin
        start_o  = trig_i & ~act_q & inc_nz_i;
        active_o = act_q;
    end

    // Set on start, clear on overflow
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else if (start_o) begin
            act_q <= 1'b1;
        end else if (ovf_i) begin
            act_q <= 1'b0;
        end
    end

endmodule : hrpwm_out_ctl

// File: rtl/hrpwm_ctrl.sv
// Top level of the oscillator-timed pulse-width modulator. It selects the
// period trigger source, then joins the output controller and the phase
// accumulator.
// Assumes: trig_sel_i is quasi-static; inc_val_i may change at any time
// and is taken only when a pulse starts.
module hrpwm_ctrl #(
    parameter int ACC_W       = 20,
    parameter int PERIOD_LEN  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] inc_val_i,
    input  logic             trig_sel_i,
    input  logic             ext_trig_i,
    output logic             pwm_o,
    output logic             busy_o
);
    import hrpwm_pkg::*;

    trig_src_e src;
    logic      tmr_tick;
    logic      ext_rise;
    logic      trig_sel;
    logic      pulse_start;
    logic      pulse_act;
    logic      nco_ovf;
    logic      inc_nz;

    hrpwm_period_timer #(.PERIOD_LEN(PERIOD_LEN)) tmr_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tmr_tick)
    );

    hrpwm_ext_trig #(.SYNC_STAGES(SYNC_STAGES)) ext_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_trig_i),
        .rise_o (ext_rise)
    );

    // Pick the period source and qualify the increment
    always_comb begin
        src      = trig_src_e'(trig_sel_i);
        trig_sel = (src == TRIG_EXT) ? ext_rise : tmr_tick;
        inc_nz   = |inc_val_i;
    end

    hrpwm_out_ctl ctl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig_sel),
        .inc_nz_i (inc_nz),
        .ovf_i    (nco_ovf),
        .start_o  (pulse_start),
        .active_o (pulse_act)
    );

    hrpwm_nco #(.ACC_W(ACC_W)) nco_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (pulse_start),
        .run_i   (pulse_act),
        .inc_i   (inc_val_i),
        .ovf_o   (nco_ovf)
    );

    // Drive the outputs from the controller state
    always_comb begin
        pwm_o  = pulse_act;
        busy_o = pulse_act;
    end

endmodule : hrpwm_ctrl

// File: rtl/hrpwm_ctrl_chk.sv
// Assertion checker for hrpwm_ctrl. It is attached to every instance by
// the bind statement at the end of this file.
// Assumes: it sees the selected trigger and the accumulator overflow.
module hrpwm_ctrl_chk #(
    parameter int ACC_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig,
    input logic             ovf,
    input logic [ACC_W-1:0] inc,
    input logic             pwm,
    input logic             busy
);
    // R9
    busy_follows_pwm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == pwm);

    // R2
    rise_from_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm) |-> ($past(trig) && ($past(inc) != '0)));

    // R3
    fall_from_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm) |-> $past(ovf));

    // R6
    trig_while_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && trig && !ovf) |=> pwm);

    // R8
    zero_inc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm && (inc == '0)) |=> !pwm);

    // R3
    ovf_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> pwm);

endmodule : hrpwm_ctrl_chk

bind hrpwm_ctrl hrpwm_ctrl_chk #(.ACC_W(ACC_W)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .trig  (trig_sel),
    .ovf   (nco_ovf),
    .inc   (inc_val_i),
    .pwm   (pwm_o),
    .busy  (busy_o)
);

// File: tb/hrpwm_ctrl_tb_top.sv
`timescale 1ns/1ps
module hrpwm_ctrl_tb_top;
    localparam int ACC_W  = 20;
    localparam int PER    = 64;
    localparam int FULL   = 1 << ACC_W;
    localparam int WD_CYC = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [ACC_W-1:0] inc_val = '0;
    logic             trig_sel = 1'b0;
    logic             ext_trig = 1'b0;
    logic             pwm;
    logic             busy;

    int n_total = 0;
    int n_pass  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    hrpwm_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_val_i  (inc_val),
        .trig_sel_i (trig_sel),
        .ext_trig_i (ext_trig),
        .pwm_o      (pwm),
        .busy_o     (busy)
    );

    // Expected width: ceil(2^20 / inc)
    function automatic int exp_width(input int inc);
        return (FULL + inc - 1) / inc;
    endfunction

    // Expected spacing of timer-mode rises for a given width
    function automatic int exp_interval(input int w);
        return (w < PER) ? PER : PER * (w / PER + 1);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_total++;
        if (act == exp) n_pass++;
        else $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    // Wait (sampling on falling edges) for a low-to-high change of pwm
    task automatic wait_rise(input int limit, output int waited, output bit ok);
        ok = 1'b0;
        waited = 0;
        for (int i = 0; i < limit; i++) begin
            logic prev;
            prev = pwm;
            @(negedge clk);
            if (!prev && pwm) begin
                ok = 1'b1;
                waited = i + 1;
                break;
            end
        end
    endtask

    // Called at the first high sample; counts the high samples and flags busy mismatches
    task automatic measure_width(output int w, output int bad_busy);
        w = 1;
        bad_busy = (busy != pwm) ? 1 : 0;
        forever begin
            @(negedge clk);
            if (busy != pwm) bad_busy++;
            if (!pwm) break;
            w++;
            if (w > 5000) break;
        end
    endtask

    task automatic wait_idle();
        while (pwm) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_total++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD_CYC, 0);
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

    initial begin
        int w, bb, waited, inc, gap;
        bit ok;
        void'($urandom(32'h5EED_0042));

        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1", "pwm in reset", int'(pwm), 0);
        chk("R1", "busy in reset", int'(busy), 0);
        inc_val = 20'd26215;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "pwm after release", int'(pwm), 0);
        chk("R1", "busy after release", int'(busy), 0);

        // R2/R3/R4: timer mode, directed width 40
        wait_rise(200, waited, ok);
        chk("R2", "timer rise seen", int'(ok), 1);
        measure_width(w, bb);
        chk("R3", "width inc=26215", w, 40);
        chk("R9", "busy tracks pwm", bb, 0);
        wait_rise(200, waited, ok);
        chk("R4", "timer interval", w + waited, PER);

        // R4: external edges are ignored in timer mode
        inc_val = 20'hFFFFF;
        measure_width(w, bb);
        wait_rise(200, waited, ok);
        measure_width(w, bb);
        chk("R3", "width inc=max", w, 2);
        ext_trig = 1'b1;
        wait_rise(200, waited, ok);
        chk("R4", "ext ignored, interval kept", w + waited, PER);
        ext_trig = 1'b0;
        measure_width(w, bb);

        // Random timer-mode widths below one period (R3, R4)
        for (int it = 0; it < 12; it++) begin
            inc = 16645 + int'($urandom % (FULL - 16645));
            inc_val = ACC_W'(inc);
            wait_rise(400, waited, ok);
            measure_width(w, bb);
            chk("R3", "random timer width", w, exp_width(inc));
            chk("R9", "random busy", bb, 0);
            wait_rise(400, waited, ok);
            chk("R4", "random timer interval", w + waited, PER);
            measure_width(w, bb);
        end

        // R6: widths at or above the period skip the ticks that fall inside
        foreach (inc_list[j]) begin
            inc_val = ACC_W'(inc_list[j]);
            wait_idle();
            wait_rise(400, waited, ok);
            measure_width(w, bb);
            chk("R3", "long width", w, exp_width(inc_list[j]));
            wait_rise(400, waited, ok);
            chk("R6", "long interval", w + waited, exp_interval(exp_width(inc_list[j])));
            measure_width(w, bb);
        end

        // R7: an increment change during a pulse has no effect until the next pulse
        inc_val = 20'd26215;
        wait_idle();
        wait_rise(400, waited, ok);
        repeat (9) @(negedge clk);
        inc_val = 20'hFFFFF;
        w = 10;
        while (pwm) begin @(negedge clk); if (pwm) w++; end
        chk("R7", "width kept after change", w, 40);
        wait_rise(400, waited, ok);
        measure_width(w, bb);
        chk("R7", "new width next pulse", w, 2);

        // R8: zero increment blocks pulses in timer mode
        inc_val = '0;
        wait_rise(300, waited, ok);
        chk("R8", "no pulse with inc=0 (timer)", int'(ok), 0);

        // R5/R10: external mode, 3-edge latency and a single pulse per edge
        trig_sel = 1'b1;
        inc_val = 20'd26215;
        repeat (10) @(negedge clk);
        ext_trig = 1'b1;
        @(negedge clk);
        chk("R5", "low after edge k", int'(pwm), 0);
        @(negedge clk);
        chk("R5", "low after edge k+1", int'(pwm), 0);
        @(negedge clk);
        chk("R5", "high after edge k+2", int'(pwm), 1);
        measure_width(w, bb);
        chk("R10", "ext width equals timer width", w, 40);
        wait_rise(300, waited, ok);
        chk("R5", "held level, no timer pulse", int'(ok), 0);
        ext_trig = 1'b0;
        repeat (5) @(negedge clk);

        // R6: an external edge during a pulse is ignored
        inc_val = 20'd5243;
        ext_trig = 1'b1;
        repeat (3) @(negedge clk);
        ext_trig = 1'b0;
        repeat (50) @(negedge clk);
        ext_trig = 1'b1;
        w = 51;
        while (pwm) begin @(negedge clk); if (pwm) w++; end
        chk("R6", "width with mid-pulse edge", w, 200);
        wait_rise(300, waited, ok);
        chk("R6", "mid-pulse edge dropped", int'(ok), 0);
        ext_trig = 1'b0;
        repeat (5) @(negedge clk);

        // R8: zero increment blocks an external edge
        inc_val = '0;
        ext_trig = 1'b1;
        wait_rise(50, waited, ok);
        chk("R8", "no pulse with inc=0 (ext)", int'(ok), 0);
        ext_trig = 1'b0;
        repeat (5) @(negedge clk);

        // Random external-mode pulses (R5, R10)
        for (int it = 0; it < 8; it++) begin
            inc = 2048 + int'($urandom % (FULL - 2048));
            inc_val = ACC_W'(inc);
            gap = 4 + int'($urandom % 20);
            repeat (gap) @(negedge clk);
            ext_trig = 1'b1;
            repeat (2) @(negedge clk);
            @(negedge clk);
            chk("R5", "random ext rise", int'(pwm), 1);
            measure_width(w, bb);
            chk("R10", "random ext width", w, exp_width(inc));
            ext_trig = 1'b0;
            repeat (4) @(negedge clk);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end

    // Increments for the R6 long-pulse cases: widths 100 and exactly 128
    int inc_list [2] = '{10486, 8192};

endmodule : hrpwm_ctrl_tb_top